// File: doc/BRIEF.md
# SDRAM Column Burst Engine with Clock Suspend

This block models the column-burst datapath on the device side of a synchronous DRAM. On each clock edge it decodes a command (NOP, READ or WRITE) together with a bank and a column address. It then runs a fixed four-beat burst against a small internal storage array. Write data is taken on the command edge and on the three internal edges that follow. Read data appears on `dout` two internal edges after the READ, with `dout_oe` marking the valid window.

Clock suspend is driven by the `cke` input. The block registers `cke` on every edge. When that registered sample is low while a burst is in flight, the next edge is swallowed inside the block. A synthesizable enable term holds every state register, the storage write port and the outputs. The clock itself is never gated. Burst counters, latency counting and driven read data therefore pause in place, and the burst resumes at the same beat once `cke` is sampled high again. When no burst is in flight, a low `cke` changes nothing.

Top module: `sdram_suspend_burst`

## Requirements
- R1: While `rst_n` is low and right after reset, `dout_oe` is 0 and `dout` is 0.
- R2: Command encoding on `cmd`: 2'b00 NOP, 2'b01 READ, 2'b10 WRITE. The code 2'b11 behaves exactly like NOP: it does not start, end or disturb any burst.
- R3: A WRITE stores `din` at column n of the addressed bank on its own edge. The next three internal edges store `din` at the following columns, which wrap within the aligned block of four: column bits [1:0] count up modulo 4 and the upper column bits stay fixed.
- R4: A READ on internal edge E0 drives column n of the addressed bank on `dout`, with `dout_oe` high, after the second internal edge following E0. The next three columns, in the same wrapped order as R3, follow one per internal edge. `dout_oe` falls after the internal edge that follows the fourth beat.
- R5: `cke` is registered on every rising edge. An edge is suspended when the previous `cke` sample is low and a burst is in flight. A burst is in flight when write beats remain, or when a read has not yet finished its latency and data phase.
- R6: With no burst in flight, a low `cke` sample has no effect, and a READ or WRITE on the next edge is accepted normally.
- R7: On a suspended edge, `cmd`, `bank`, `col` and `din` are ignored. Nothing is written to storage and no burst starts or ends.
- R8: On a suspended edge, `dout` and `dout_oe` keep the values they had.
- R9: Suspended edges do not advance the beat counters and do not count toward the read latency. After resuming, the burst continues at the same beat, with no beat lost or repeated.
- R10: A READ or WRITE accepted on an internal edge during a burst ends that burst at once and starts the new one. An ended write stores no further beats. A READ stores no data on its own edge. Either command drops `dout_oe` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable, sampled every edge |
| cmd | input | 2 | Command code (R2) |
| bank | input | BANK_W | Bank address for READ/WRITE |
| col | input | COL_W | Starting column for READ/WRITE |
| din | input | DATA_W | Write data for the current beat |
| dout | output | DATA_W | Read data |
| dout_oe | output | 1 | Read data valid / output enable |

## Verification
A write beat lands in storage on the same edge that carries it, so the bench updates its reference array for exactly the edges it knows are internal. It works this out from the `cke` value it drove one edge earlier. A read beat is due after the second internal edge past the READ. The bench checks that timing with per-cycle `dout_oe` probes in directed runs, both with and without a swallowed edge during the latency. In random runs, the monitor samples on the falling edge and pops one expected value only after an internal edge. After a suspended edge it instead demands that `dout` and `dout_oe` be unchanged.

// File: rtl/sbe_pkg.sv
package sbe_pkg;
    typedef enum logic [1:0] {
        SBE_NOP   = 2'b00,
        SBE_READ  = 2'b01,
        SBE_WRITE = 2'b10,
        SBE_RSVD  = 2'b11
    } sbe_cmd_e;

    localparam int SBE_BURST_LEN = 4;
    localparam int SBE_CAS_LAT   = 2;
endpackage

// File: rtl/sbe_col_wrap.sv
// Column of a given beat inside an aligned burst block (wrapping order).
module sbe_col_wrap #(
    parameter int COL_W  = 4,
    parameter int BEAT_W = 2
) (
    input  logic [COL_W-1:0]  base,
    input  logic [BEAT_W-1:0] beat,
    output logic [COL_W-1:0]  col_o
);
    generate
        if (COL_W == BEAT_W) begin : g_full
            assign col_o = base + beat;
        end else begin : g_part
            logic [BEAT_W-1:0] low_sum;
            assign low_sum = base[BEAT_W-1:0] + beat;
            assign col_o   = {base[COL_W-1:BEAT_W], low_sum};
        end
    endgenerate
endmodule

// File: rtl/sbe_store.sv
// Storage array: one synchronous write port, one combinational read port.
module sbe_store #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/sdram_suspend_burst.sv
module sdram_suspend_burst
    import sbe_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BANK_W = 2,
    parameter int COL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic [1:0]        cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic [COL_W-1:0]  col,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);
    localparam int ADDR_W = BANK_W + COL_W;
    localparam int BL     = SBE_BURST_LEN;
    localparam int CL     = SBE_CAS_LAT;
    localparam int BEAT_W = $clog2(BL);
    localparam int STEP_W = $clog2(CL + BL + 1);

    typedef struct packed {
        logic              cke;
        logic              wr_act;
        logic [BEAT_W-1:0] wr_beat;
        logic [BANK_W-1:0] wr_bank;
        logic [COL_W-1:0]  wr_col;
        logic [STEP_W-1:0] rd_step;
        logic [BANK_W-1:0] rd_bank;
        logic [COL_W-1:0]  rd_col;
        logic [DATA_W-1:0] dout;
        logic              oe;
    } st_t;

    st_t st_d, st_q;

    logic              busy;
    logic              run;
    logic [COL_W-1:0]  wr_col_cur;
    logic [COL_W-1:0]  rd_col_cur;
    logic [BEAT_W-1:0] rd_beat;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_rdata;

    // Internal edge enable: swallowed only when a burst is in flight.
    assign busy    = st_q.wr_act | (st_q.rd_step != '0);
    assign run     = st_q.cke | ~busy;
    assign rd_beat = BEAT_W'(st_q.rd_step - STEP_W'(CL));

    sbe_col_wrap #(.COL_W(COL_W), .BEAT_W(BEAT_W)) u_wr_wrap (
        .base (st_q.wr_col),
        .beat (st_q.wr_beat),
        .col_o(wr_col_cur)
    );

    sbe_col_wrap #(.COL_W(COL_W), .BEAT_W(BEAT_W)) u_rd_wrap (
        .base (st_q.rd_col),
        .beat (rd_beat),
        .col_o(rd_col_cur)
    );

    sbe_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk  (clk),
        .we   (mem_we),
        .waddr(mem_waddr),
        .wdata(din),
        .raddr({st_q.rd_bank, rd_col_cur}),
        .rdata(mem_rdata)
    );

    always_comb begin
        st_d      = st_q;
        st_d.cke  = cke;
        mem_we    = 1'b0;
        mem_waddr = {st_q.wr_bank, wr_col_cur};
        if (run) begin
            // write burst progress
            if (st_q.wr_act) begin
                mem_we       = 1'b1;
                st_d.wr_beat = st_q.wr_beat + BEAT_W'(1);
                if (st_q.wr_beat == BEAT_W'(BL - 1)) st_d.wr_act = 1'b0;
            end
            // read latency and data phase
            if (st_q.rd_step != '0) begin
                if (st_q.rd_step == STEP_W'(CL + BL)) begin
                    st_d.rd_step = '0;
                    st_d.oe      = 1'b0;
                end else begin
                    st_d.rd_step = st_q.rd_step + STEP_W'(1);
                    if (st_q.rd_step >= STEP_W'(CL)) begin
                        st_d.dout = mem_rdata;
                        st_d.oe   = 1'b1;
                    end
                end
            end
            // new commands end any burst in flight
            if (cmd == SBE_WRITE) begin
                mem_we       = 1'b1;
                mem_waddr    = {bank, col};
                st_d.wr_act  = 1'b1;
                st_d.wr_beat = BEAT_W'(1);
                st_d.wr_bank = bank;
                st_d.wr_col  = col;
                st_d.rd_step = '0;
                st_d.oe      = 1'b0;
            end else if (cmd == SBE_READ) begin
                mem_we       = 1'b0;
                st_d.wr_act  = 1'b0;
                st_d.wr_beat = '0;
                st_d.rd_step = STEP_W'(1);
                st_d.rd_bank = bank;
                st_d.rd_col  = col;
                st_d.oe      = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cke <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout    = st_q.dout;
    assign dout_oe = st_q.oe;
endmodule

// File: rtl/sbe_checker.sv
module sbe_checker #(
    parameter int DATA_W = 16,
    parameter int BEAT_W = 2,
    parameter int STEP_W = 3,
    parameter int CL     = 2,
    parameter int BL     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke_q,
    input logic              busy,
    input logic [1:0]        cmd,
    input logic              wr_act,
    input logic [BEAT_W-1:0] wr_beat,
    input logic [STEP_W-1:0] rd_step,
    input logic              mem_we,
    input logic [DATA_W-1:0] dout,
    input logic              dout_oe
);
    // R8: outputs frozen across a swallowed edge
    p_hold_outputs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !cke_q |=> $stable(dout) && $stable(dout_oe));

    // R9: counters frozen across a swallowed edge
    p_freeze_counters_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !cke_q |=> $stable(rd_step) && $stable(wr_beat) && $stable(wr_act));

    // R7: no storage write on a swallowed edge
    p_no_write_suspended_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !cke_q |-> !mem_we);

    // R4: valid window lies strictly inside the read data phase
    p_oe_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe == ((rd_step > STEP_W'(CL)) && (rd_step <= STEP_W'(CL + BL))));

    // R6: an idle block accepts WRITE whatever cke was
    p_idle_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && cmd == 2'b10 |=> wr_act && wr_beat == BEAT_W'(1));
endmodule

bind sdram_suspend_burst sbe_checker #(
    .DATA_W(DATA_W),
    .BEAT_W(BEAT_W),
    .STEP_W(STEP_W),
    .CL    (CL),
    .BL    (BL)
) u_sbe_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .cke_q  (st_q.cke),
    .busy   (busy),
    .cmd    (cmd),
    .wr_act (st_q.wr_act),
    .wr_beat(st_q.wr_beat),
    .rd_step(st_q.rd_step),
    .mem_we (mem_we),
    .dout   (dout),
    .dout_oe(dout_oe)
);

// File: tb/sdram_suspend_burst_bench.sv
module sdram_suspend_burst_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 16;
    localparam int BANK_W = 2;
    localparam int COL_W  = 4;
    localparam int WORDS  = 1 << (BANK_W + COL_W);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cke = 1'b1;
    logic [1:0]        cmd = 2'b00;
    logic [BANK_W-1:0] bank = '0;
    logic [COL_W-1:0]  col = '0;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] dout;
    logic              dout_oe;

    sdram_suspend_burst #(.DATA_W(DATA_W), .BANK_W(BANK_W), .COL_W(COL_W)) u_sdram_suspend_burst (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .bank(bank),
        .col(col), .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    logic [DATA_W-1:0] ref_mem [WORDS];
    logic [DATA_W-1:0] exp_q [$];
    logic last_cke = 1'b1;
    logic cke_e0 = 1'b1, cke_e1 = 1'b1;
    logic m_prev_oe = 1'b0;
    logic [DATA_W-1:0] m_prev_dout = '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        cke_e1 <= cke_e0;
        cke_e0 <= cke;
        if (cyc > 50000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected <50000 cycles", cyc);
            summary();
        end
    end

    // Monitor: pop one expected beat per internal edge while valid.
    always @(negedge clk) begin
        if (rst_n) begin
            if (m_prev_oe && !cke_e1) begin
                chk(dout_oe == 1'b1, "R8 oe hold", dout_oe, 1);
                chk(dout == m_prev_dout, "R8 data hold", dout, m_prev_dout);
            end else if (dout_oe) begin
                if (exp_q.size() == 0) chk(1'b0, "R4 unexpected beat", dout, 0);
                else begin
                    logic [DATA_W-1:0] e;
                    e = exp_q.pop_front();
                    chk(dout == e, "R4/R9 read beat", dout, e);
                end
            end
            m_prev_oe   = dout_oe;
            m_prev_dout = dout;
        end
    end

    function automatic int idx(input logic [BANK_W-1:0] b, input logic [COL_W-1:0] c, input int n);
        logic [1:0] lo;
        lo = c[1:0] + 2'(n);
        return int'({b, c[COL_W-1:2], lo});
    endfunction

    task automatic tick(input logic c, input logic [1:0] cm, input logic [BANK_W-1:0] b,
                        input logic [COL_W-1:0] cl, input logic [DATA_W-1:0] d);
        @(negedge clk);
        cke = c; cmd = cm; bank = b; col = cl; din = d;
        last_cke = c;
    endtask

    function automatic logic rnd_cke(input int low_pct);
        return ($urandom_range(0, 99) >= low_pct);
    endfunction

    // Junk stimulus driven on swallowed edges (R7).
    task automatic junk(input logic c);
        tick(c, $urandom_range(0, 1) ? 2'b10 : 2'b01, BANK_W'($urandom), COL_W'($urandom), DATA_W'($urandom));
    endtask

    task automatic write_burst(input logic [BANK_W-1:0] b, input logic [COL_W-1:0] c, input int low_pct);
        int n;
        logic [DATA_W-1:0] d;
        d = DATA_W'($urandom);
        tick(rnd_cke(low_pct), 2'b10, b, c, d);
        ref_mem[idx(b, c, 0)] = d;
        n = 1;
        while (n < 4) begin
            if (!last_cke) junk(rnd_cke(low_pct));
            else begin
                d = DATA_W'($urandom);
                tick(rnd_cke(low_pct), $urandom_range(0, 1) ? 2'b11 : 2'b00, BANK_W'($urandom), COL_W'($urandom), d);
                ref_mem[idx(b, c, n)] = d;
                n++;
            end
        end
    endtask

    task automatic read_burst(input logic [BANK_W-1:0] b, input logic [COL_W-1:0] c, input int low_pct);
        int n;
        for (int k = 0; k < 4; k++) exp_q.push_back(ref_mem[idx(b, c, k)]);
        tick(rnd_cke(low_pct), 2'b01, b, c, '0);
        n = 0;
        while (n < 6) begin
            if (!last_cke) junk(rnd_cke(low_pct));
            else begin
                tick(rnd_cke(low_pct), 2'b00, '0, '0, '0);
                n++;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(dout_oe == 1'b0, "R1 oe in reset", dout_oe, 0);
        chk(dout == '0, "R1 dout in reset", dout, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dout_oe == 1'b0, "R1 oe after reset", dout_oe, 0);

        // Fill storage, cke high throughout.
        for (int b = 0; b < 4; b++)
            for (int c = 0; c < 16; c += 4)
                write_burst(BANK_W'(b), COL_W'(c), 0);
        tick(1, 2'b00, '0, '0, '0);

        // R6 + R4: idle with cke low, then READ; normal latency.
        repeat (3) tick(0, 2'b00, '0, '0, '0);
        for (int k = 0; k < 4; k++) exp_q.push_back(ref_mem[idx(2, 6, k)]);
        tick(1, 2'b01, 2, 6, '0);                                   // E0
        tick(1, 2'b00, '0, '0, '0); chk(dout_oe == 0, "R4 oe after E0", dout_oe, 0);
        tick(1, 2'b00, '0, '0, '0); chk(dout_oe == 0, "R4 oe after E1", dout_oe, 0);
        tick(1, 2'b00, '0, '0, '0); chk(dout_oe == 1, "R6 R4 oe after E2", dout_oe, 1);
        repeat (4) tick(1, 2'b00, '0, '0, '0);
        chk(dout_oe == 0, "R4 oe drop", dout_oe, 0);

        // R9: swallowed edge during latency delays first beat by one.
        for (int k = 0; k < 4; k++) exp_q.push_back(ref_mem[idx(1, 9, k)]);
        tick(0, 2'b01, 1, 9, '0);                                   // E0, cke low
        tick(1, 2'b10, 3, 0, 16'hdead); chk(dout_oe == 0, "R9 oe after E0", dout_oe, 0); // E1 swallowed
        tick(1, 2'b00, '0, '0, '0); chk(dout_oe == 0, "R9 oe after E1", dout_oe, 0);
        tick(1, 2'b00, '0, '0, '0); chk(dout_oe == 0, "R9 oe after E2", dout_oe, 0);
        tick(1, 2'b00, '0, '0, '0); chk(dout_oe == 1, "R9 oe after E3", dout_oe, 1);
        repeat (4) tick(1, 2'b00, '0, '0, '0);

        // R2: reserved code while idle changes nothing.
        tick(1, 2'b11, 0, 0, 16'hbeef);
        tick(1, 2'b00, '0, '0, '0);
        chk(dout_oe == 0, "R2 reserved idle", dout_oe, 0);

        // R10: WRITE ended by READ after two beats.
        begin
            logic [DATA_W-1:0] a0, a1;
            a0 = 16'h1111; a1 = 16'h2222;
            tick(1, 2'b10, 3, 5, a0); ref_mem[idx(3, 5, 0)] = a0;
            tick(1, 2'b00, '0, '0, a1); ref_mem[idx(3, 5, 1)] = a1;
            for (int k = 0; k < 4; k++) exp_q.push_back(ref_mem[idx(3, 4, k)]);
            tick(1, 2'b01, 3, 4, 16'h3333);
            repeat (7) tick(1, 2'b00, '0, '0, '0);
        end

        // R10: READ ended by WRITE after first beat.
        exp_q.push_back(ref_mem[idx(0, 2, 0)]);
        tick(1, 2'b01, 0, 2, '0);
        tick(1, 2'b00, '0, '0, '0);
        tick(1, 2'b00, '0, '0, '0);
        tick(1, 2'b10, 2, 12, 16'h4444); ref_mem[idx(2, 12, 0)] = 16'h4444;
        chk(dout_oe == 1, "R10 first beat out", dout_oe, 1);
        tick(1, 2'b00, '0, '0, 16'h5555); ref_mem[idx(2, 12, 1)] = 16'h5555;
        chk(dout_oe == 0, "R10 oe dropped by WRITE", dout_oe, 0);
        tick(1, 2'b00, '0, '0, 16'h6666); ref_mem[idx(2, 12, 2)] = 16'h6666;
        tick(1, 2'b00, '0, '0, 16'h7777); ref_mem[idx(2, 12, 3)] = 16'h7777;
        tick(1, 2'b00, '0, '0, '0);

        // R3/R5/R7/R9: random bursts with random cke.
        for (int i = 0; i < 60; i++) begin
            if ($urandom_range(0, 1)) write_burst(BANK_W'($urandom), COL_W'($urandom), 40);
            else read_burst(BANK_W'($urandom), COL_W'($urandom), 40);
            if ($urandom_range(0, 3) == 0) tick(0, 2'b00, '0, '0, '0);
        end

        // R3: full read-back with cke high.
        for (int b = 0; b < 4; b++)
            for (int c = 0; c < 16; c += 4)
                read_burst(BANK_W'(b), COL_W'(c), 0);
        repeat (4) tick(1, 2'b00, '0, '0, '0);
        chk(exp_q.size() == 0, "R4 all beats delivered", exp_q.size(), 0);
        summary();
    end
endmodule